// File: doc/BRIEF.md
# Conditional Arithmetic Barrel Shifter

This block shifts a 16-bit operand inside a 32-bit result field. The operand is first placed in the upper half or the lower half of the field. It is then moved by a signed shift code: a positive code shifts left and a negative code shifts right. The distance is the magnitude of the code.

Two shift kinds are offered. An arithmetic shift replicates the operand's sign bit into the upper bits and on right shifts. A logical shift fills with zeros. The shifted field either replaces the 32-bit result register or is ORed into it.

Every operation depends on a condition input. When the condition is low, nothing changes. A 32-bit value can be shifted with two operations that use the same code. The first is an arithmetic shift of the upper word, placed high, that replaces the register. The second is a logical shift of the lower word, placed low, that is ORed into the register.

Top module: `cond_barrel_shifter`

## Requirements
- R1: While `rst` is high at a rising clock edge, the result register is cleared to 0x00000000.
- R2: When `cond_i` is 0 at a rising edge, `res_o` keeps its value, whatever the other inputs are.
- R3: With `hi_i`=1 (upper placement), the operand fills bits 31..16 of the field and bits 15..0 are zero before the shift. A code of 0 therefore yields {din_i, 16'h0000}.
- R4: With `hi_i`=0 (lower placement), the operand fills bits 15..0. An arithmetic operation (`arith_i`=1) fills bits 31..16 with `din_i[15]`. A logical operation (`arith_i`=0) fills them with zero.
- R5: `code_i` is an 8-bit two's complement number. A positive value n shifts the field left by n. Zeros enter at bit 0, and bits moved past bit 31 are lost.
- R6: A negative value -n shifts the field right by n, and bits moved below bit 0 are lost. An arithmetic shift fills from the top with field bit 31. A logical shift fills with zeros.
- R7: A shift magnitude of 32 or more (up to 128) gives all zeros. The one exception is an arithmetic right shift, which gives 32 copies of field bit 31.
- R8: With `or_i`=1, the new result is the old result ORed bitwise with the shifted field. With `or_i`=0, the shifted field replaces the old result.
- R9: An operation with `cond_i`=1 takes effect at that rising edge. `res_o` shows it from that edge on and keeps its old value before it.
- R10: Shifting a 32-bit value V by code c can be done in two operations with the same code. The first is arithmetic, upper placement, replace, on V[31:16]. The second is logical, lower placement, OR, on V[15:0]. The result equals V shifted arithmetically by c as a 32-bit word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cond_i | input | 1 | Condition true; the operation executes when this is 1 |
| arith_i | input | 1 | 1 = arithmetic shift, 0 = logical shift |
| hi_i | input | 1 | 1 = operand placed in bits 31..16, 0 = bits 15..0 |
| or_i | input | 1 | 1 = OR into the result register, 0 = overwrite it |
| code_i | input | 8 | Signed shift code, two's complement |
| din_i | input | 16 | Operand to shift |
| res_o | output | 32 | Result register |

## Verification
The shift path is combinational, and the only register is the result register. An operation driven before edge k is therefore visible on `res_o` just after edge k. The bench changes inputs on falling edges and reads `res_o` on the falling edge that follows the capturing edge, half a cycle after the update.

For R9, the bench also samples `res_o` between driving an enabled operation and its edge, to confirm the old value is still held. The hold checks for R2 run a few cycles with `cond_i` low and varied operands, then read the register.

// File: rtl/shf_pkg.sv
package shf_pkg;

    localparam int OPND_W  = 16;
    localparam int CODE_W  = 8;

    typedef enum logic {
        KIND_LOGIC = 1'b0,
        KIND_ARITH = 1'b1
    } shf_kind_e;

    typedef enum logic {
        SLOT_LOW  = 1'b0,
        SLOT_HIGH = 1'b1
    } shf_slot_e;

    typedef struct packed {
        shf_kind_e             kind;
        shf_slot_e             slot;
        logic                  merge;
        logic [CODE_W-1:0]     code;
        logic [OPND_W-1:0]     data;
    } shf_cmd_t;

    // Magnitude of a two's complement shift code (most negative code maps to 2**(CODE_W-1))
    function automatic logic [CODE_W-1:0] code_mag(input logic [CODE_W-1:0] c);
        return c[CODE_W-1] ? (~c + 1'b1) : c;
    endfunction

endpackage

// File: rtl/shf_place.sv
module shf_place #(
    parameter int OPND_W = 16,
    localparam int FLD_W = 2 * OPND_W
) (
    input  logic [OPND_W-1:0] data_i,
    input  logic              slot_hi_i,
    input  logic              arith_i,
    output logic [FLD_W-1:0]  field_o
);

    logic ext_bit;

    always_comb begin
        ext_bit = arith_i & data_i[OPND_W-1];
        if (slot_hi_i)
            field_o = {data_i, {OPND_W{1'b0}}};
        else
            field_o = {{OPND_W{ext_bit}}, data_i};
    end

endmodule

// File: rtl/shf_core.sv
module shf_core #(
    parameter int FLD_W  = 32,
    parameter int CODE_W = 8,
    localparam int STG   = $clog2(FLD_W)
) (
    input  logic [FLD_W-1:0]  field_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              arith_i,
    output logic [FLD_W-1:0]  shifted_o
);

    logic              go_right;
    logic              too_far;
    logic              fill;
    logic [CODE_W-1:0] mag;

    logic [FLD_W-1:0] up_stage [STG+1];
    logic [FLD_W-1:0] dn_stage [STG+1];

    always_comb begin
        go_right = code_i[CODE_W-1];
        mag      = shf_pkg::code_mag(code_i);
        too_far  = |mag[CODE_W-1:STG];
        fill     = arith_i & field_i[FLD_W-1];
    end

    assign up_stage[0] = field_i;
    assign dn_stage[0] = field_i;

    for (genvar k = 0; k < STG; k++) begin : g_stage
        localparam int AMT = 1 << k;
        always_comb begin
            up_stage[k+1] = mag[k] ? {up_stage[k][FLD_W-1-AMT:0], {AMT{1'b0}}} : up_stage[k];
            dn_stage[k+1] = mag[k] ? {{AMT{fill}}, dn_stage[k][FLD_W-1:AMT]} : dn_stage[k];
        end
    end

    always_comb begin
        if (too_far)
            shifted_o = go_right ? {FLD_W{fill}} : '0;
        else
            shifted_o = go_right ? dn_stage[STG] : up_stage[STG];
    end

endmodule

// File: rtl/cond_barrel_shifter.sv
module cond_barrel_shifter #(
    parameter int OPND_W = shf_pkg::OPND_W,
    parameter int CODE_W = shf_pkg::CODE_W,
    localparam int FLD_W = 2 * OPND_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cond_i,
    input  logic              arith_i,
    input  logic              hi_i,
    input  logic              or_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic [OPND_W-1:0] din_i,
    output logic [FLD_W-1:0]  res_o
);

    import shf_pkg::*;

    shf_cmd_t         cmd;
    logic [FLD_W-1:0] field;
    logic [FLD_W-1:0] shifted;
    logic [FLD_W-1:0] res_q;

    always_comb begin
        cmd.kind  = arith_i ? KIND_ARITH : KIND_LOGIC;
        cmd.slot  = hi_i ? SLOT_HIGH : SLOT_LOW;
        cmd.merge = or_i;
        cmd.code  = code_i;
        cmd.data  = din_i;
    end

    shf_place #(.OPND_W(OPND_W)) u_place (
        .data_i    (cmd.data),
        .slot_hi_i (cmd.slot == SLOT_HIGH),
        .arith_i   (cmd.kind == KIND_ARITH),
        .field_o   (field)
    );

    shf_core #(.FLD_W(FLD_W), .CODE_W(CODE_W)) u_core (
        .field_i   (field),
        .code_i    (cmd.code),
        .arith_i   (cmd.kind == KIND_ARITH),
        .shifted_o (shifted)
    );

    always_ff @(posedge clk) begin
        if (rst)
            res_q <= '0;
        else if (cond_i)
            res_q <= cmd.merge ? (res_q | shifted) : shifted;
    end

    assign res_o = res_q;

    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> res_o == '0);

    // R2
    cond_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cond_i |=> $stable(res_o));

    // R8
    or_keeps_old_chk: assert property (@(posedge clk) disable iff (rst)
        (cond_i && or_i) |=> ((res_o & $past(res_o)) == $past(res_o)));

    // R3
    hi_low_half_chk: assert property (@(posedge clk) disable iff (rst)
        (cond_i && hi_i && !or_i && code_i == '0) |=> res_o[OPND_W-1:0] == '0);

    // R6
    arith_sign_chk: assert property (@(posedge clk) disable iff (rst)
        (cond_i && arith_i && !or_i && code_i[CODE_W-1] && din_i[OPND_W-1]) |=> res_o[FLD_W-1]);

endmodule

// File: tb/sim_cond_barrel_shifter.sv
module sim_cond_barrel_shifter;

    logic        clk = 1'b0;
    logic        rst;
    logic        cond_i, arith_i, hi_i, or_i;
    logic [7:0]  code_i;
    logic [15:0] din_i;
    logic [31:0] res_o;

    int total = 0;
    int bad   = 0;
    logic [31:0] model_q;

    always #5 clk = ~clk;

    cond_barrel_shifter u0 (
        .clk(clk), .rst(rst), .cond_i(cond_i), .arith_i(arith_i),
        .hi_i(hi_i), .or_i(or_i), .code_i(code_i), .din_i(din_i), .res_o(res_o)
    );

    function automatic logic [31:0] ref_shift(input logic [15:0] d, input logic signed [7:0] c,
                                              input logic ar, input logic hi);
        logic [31:0] f;
        int n;
        if (hi) f = {d, 16'h0000};
        else    f = ar ? {{16{d[15]}}, d} : {16'h0000, d};
        n = int'(c);
        if (n >= 0) return (n >= 32) ? 32'h0 : (f << n);
        n = -n;
        if (ar) return (n >= 32) ? {32{f[31]}} : 32'($signed(f) >>> n);
        return (n >= 32) ? 32'h0 : (f >> n);
    endfunction

    function automatic logic [31:0] ref_dp(input logic [31:0] v, input logic signed [7:0] c);
        int n;
        n = int'(c);
        if (n >= 0) return (n >= 32) ? 32'h0 : (v << n);
        n = -n;
        return (n >= 32) ? {32{v[31]}} : 32'($signed(v) >>> n);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic op(input logic ar, input logic hi, input logic orf,
                      input logic [7:0] c, input logic [15:0] d, input string req);
        logic [31:0] s;
        @(negedge clk);
        arith_i = ar; hi_i = hi; or_i = orf; code_i = c; din_i = d; cond_i = 1'b1;
        s = ref_shift(d, c, ar, hi);
        model_q = orf ? (model_q | s) : s;
        @(negedge clk);
        cond_i = 1'b0;
        chk(req, res_o, model_q);
    endtask

    task automatic t_reset;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        model_q = 32'h0;
        chk("R1", res_o, 32'h0);
    endtask

    task automatic t_place;
        op(1'b1, 1'b1, 1'b0, 8'd0, 16'hA5C3, "R3");
        op(1'b0, 1'b1, 1'b0, 8'd0, 16'h1234, "R3");
        op(1'b1, 1'b0, 1'b0, 8'd0, 16'h8001, "R4");
        op(1'b0, 1'b0, 1'b0, 8'd0, 16'h8001, "R4");
        op(1'b1, 1'b0, 1'b0, 8'd0, 16'h7FFF, "R4");
    endtask

    task automatic t_left;
        op(1'b1, 1'b1, 1'b0, 8'd4,  16'hF00F, "R5");
        op(1'b0, 1'b0, 1'b0, 8'd20, 16'hBEEF, "R5");
        op(1'b1, 1'b0, 1'b0, 8'd31, 16'h0003, "R5");
        for (int c = 0; c < 32; c += 3)
            op(c[0], c[1], 1'b0, 8'(c), 16'hC35A, "R5");
    endtask

    task automatic t_right;
        op(1'b1, 1'b1, 1'b0, -8'sd4,  16'h8421, "R6");
        op(1'b0, 1'b1, 1'b0, -8'sd4,  16'h8421, "R6");
        op(1'b1, 1'b0, 1'b0, -8'sd3,  16'hFF07, "R6");
        op(1'b0, 1'b0, 1'b0, -8'sd17, 16'hFFFF, "R6");
        for (int c = 1; c < 32; c += 2)
            op(c[1], c[2], 1'b0, 8'(-c), 16'h9A3C, "R6");
    endtask

    task automatic t_big;
        op(1'b1, 1'b1, 1'b0, 8'd32,   16'hFFFF, "R7");
        op(1'b1, 1'b1, 1'b0, 8'd127,  16'h8000, "R7");
        op(1'b1, 1'b1, 1'b0, -8'sd32, 16'h8000, "R7");
        op(1'b1, 1'b0, 1'b0, 8'h80,   16'h8000, "R7");
        op(1'b0, 1'b1, 1'b0, 8'h80,   16'h8000, "R7");
        op(1'b1, 1'b1, 1'b0, -8'sd40, 16'h7FFF, "R7");
    endtask

    task automatic t_or;
        op(1'b0, 1'b1, 1'b0, 8'd0,   16'hF000, "R8");
        op(1'b0, 1'b0, 1'b1, 8'd0,   16'h000F, "R8");
        op(1'b0, 1'b0, 1'b1, 8'd8,   16'h0033, "R8");
        op(1'b0, 1'b0, 1'b0, -8'sd1, 16'h0002, "R8");
    endtask

    task automatic t_hold;
        op(1'b1, 1'b1, 1'b0, 8'd3, 16'h5A5A, "R2");
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            cond_i = 1'b0; arith_i = i[0]; hi_i = i[1]; or_i = ~i[0];
            code_i = 8'(i * 37); din_i = 16'(16'hFFFF - i);
        end
        @(negedge clk);
        chk("R2", res_o, model_q);
    endtask

    task automatic t_timing;
        logic [31:0] old;
        old = model_q;
        @(negedge clk);
        arith_i = 1'b0; hi_i = 1'b1; or_i = 1'b0; code_i = 8'd1; din_i = 16'h4001; cond_i = 1'b1;
        #2;
        chk("R9", res_o, old);
        model_q = ref_shift(16'h4001, 8'd1, 1'b0, 1'b1);
        @(posedge clk);
        #1;
        cond_i = 1'b0;
        chk("R9", res_o, model_q);
    endtask

    task automatic t_double(input logic [31:0] v, input logic [7:0] c);
        op(1'b1, 1'b1, 1'b0, c, v[31:16], "R10");
        op(1'b0, 1'b0, 1'b1, c, v[15:0],  "R10");
        chk("R10", res_o, ref_dp(v, c));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; cond_i = 1'b0; arith_i = 1'b0; hi_i = 1'b0; or_i = 1'b0;
        code_i = 8'h0; din_i = 16'h0; model_q = 32'h0;
        repeat (2) @(negedge clk);
        t_reset;
        t_place;
        t_left;
        t_right;
        t_big;
        t_or;
        t_hold;
        t_timing;
        t_double(32'h8000_1234, -8'sd4);
        t_double(32'h8000_1234, 8'd4);
        t_double(32'h7FFF_8001, -8'sd20);
        t_double(32'hC0DE_F00D, -8'sd31);
        t_double(32'h9000_8000, -8'sd16);
        t_double(32'h0123_ABCD, 8'd12);
        t_reset;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule